// File: doc/BRIEF.md
# TDMA Slot Transmit Scheduler

This block decides, at the start of every slot of a static time-division schedule, whether the node puts a frame on the bus and which frame it sends. A schedule table is indexed by round and slot. Each entry marks the slot as empty, as owned by one of this node's timed messages, or as owned by another node. The time base outside the block pulses `slot_start` at each slot's action time and presents the current round and slot numbers. One cycle later the scheduler raises `tx_req` for the bit engine, carrying either a timed message or an asynchronous one.

Each timed message has a one-deep buffer. A host write replaces whatever the buffer held, and an owned slot always sends the latest value. Asynchronous messages go through a first-in first-out queue. They may only start at the action time of an empty slot. One that loses arbitration, or otherwise fails, stays at the head of the queue and is offered again at the next empty slot. A failed timed frame is never retried, so a frame cannot run over into the following slot. The bit engine reports the end of each frame on `tx_done` and reports success on `tx_ok`.

Top module: `tdma_tx_sched`

## Requirements
- R1: A table write stores a kind and a message index for one (round, slot) pair. Kind codes are: 0 for an empty slot, 1 for a slot owned by this node's timed message `tbl_id`, 2 or 3 for a slot owned by another node. Lookup at `slot_start` uses `cur_round`/`cur_slot`.
- R2: `tx_req` is high only in the cycle that follows a cycle with `slot_start` high. No request is raised in response to `tx_done`, whatever the value of `tx_ok`.
- R3: At an owned slot, the request carries the most recent value written to that timed buffer, with `tx_async`=0. A later write overwrites an earlier one. A buffer that has never been written produces no request.
- R4: A slot of kind 2 or 3 never produces a request, even when the asynchronous queue holds messages.
- R5: At an empty slot, if the queue is not empty, the request carries the queue head with `tx_async`=1. If the queue is empty, there is no request.
- R6: Asynchronous messages are sent in the order in which they were written.
- R7: If `tx_done` arrives with `tx_ok`=0 after an asynchronous request, the head message stays queued and is sent again at the next empty slot. With `tx_ok`=1 it is removed from the queue.
- R8: A timed frame that ends with `tx_ok`=0 is dropped. It is sent again only at its next owned slot.
- R9: When the queue holds `AQ_DEPTH` messages, `amsg_full` is high. A further write is discarded and sets `amsg_ovf`, which stays high until reset.
- R10: After reset there is no request, the queue is empty, `amsg_full` and `amsg_ovf` are low, every table entry is empty (kind 0), and no timed buffer is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Schedule table write strobe |
| tbl_round | input | RND_W | Round of the entry written |
| tbl_slot | input | SLT_W | Slot of the entry written |
| tbl_kind | input | 2 | Slot kind code (R1) |
| tbl_id | input | ID_W | Timed message index for an owned slot |
| tmsg_we | input | 1 | Timed buffer write strobe |
| tmsg_id | input | ID_W | Timed buffer selected |
| tmsg_data | input | DATA_W | Timed message content |
| amsg_we | input | 1 | Asynchronous queue write strobe |
| amsg_data | input | DATA_W | Asynchronous message content |
| amsg_full | output | 1 | Queue holds AQ_DEPTH messages |
| amsg_ovf | output | 1 | Sticky: a write was discarded |
| slot_start | input | 1 | Action time pulse of the current slot |
| cur_round | input | RND_W | Current round number |
| cur_slot | input | SLT_W | Current slot number |
| tx_req | output | 1 | One-cycle transmit request |
| tx_async | output | 1 | Request carries an asynchronous message |
| tx_data | output | DATA_W | Message to transmit |
| tx_done | input | 1 | Frame finished on the bus |
| tx_ok | input | 1 | Frame succeeded (valid with tx_done) |

## Verification
The hardest case to reach is a failed asynchronous frame that has to stay at the queue head while the queue is also full. In that state the retry, the ordering, and the rejection of an extra write all interact. The stimulus fills the queue to capacity and then writes once more to set the overflow flag. It next offers an empty slot and answers it with a failed completion. It then checks that the same message returns at an empty slot of a different round, that the queue still reports full, and that the discarded message never appears. Owned slots are visited both before and after their buffer is written, and again after a failed frame, so that dropping a failed frame is distinguished from retrying it.

// File: rtl/tdma_sched_pkg.sv
package tdma_sched_pkg;
  typedef enum logic [1:0] {
    SK_EMPTY   = 2'd0,
    SK_OWN     = 2'd1,
    SK_FOREIGN = 2'd2,
    SK_OTHER   = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table #(
  parameter int ROUNDS = 4,
  parameter int SLOTS  = 8,
  parameter int RND_W  = 2,
  parameter int SLT_W  = 3,
  parameter int ID_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [RND_W-1:0]                wr_round,
  input  logic [SLT_W-1:0]                wr_slot,
  input  tdma_sched_pkg::slot_kind_e      wr_kind,
  input  logic [ID_W-1:0]                 wr_id,
  input  logic [RND_W-1:0]                rd_round,
  input  logic [SLT_W-1:0]                rd_slot,
  output tdma_sched_pkg::slot_kind_e      rd_kind,
  output logic [ID_W-1:0]                 rd_id
);
  import tdma_sched_pkg::*;
  localparam int ENTRIES = ROUNDS * SLOTS;
  localparam int IDX_W   = $clog2(ENTRIES) + 1;

  slot_kind_e      kind_q [ENTRIES];
  logic [ID_W-1:0] id_q   [ENTRIES];

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_in_range, rd_in_range;

  always_comb begin
    wr_idx      = IDX_W'(wr_round) * IDX_W'(SLOTS) + IDX_W'(wr_slot);
    rd_idx      = IDX_W'(rd_round) * IDX_W'(SLOTS) + IDX_W'(rd_slot);
    wr_in_range = (int'(wr_round) < ROUNDS) && (int'(wr_slot) < SLOTS);
    rd_in_range = (int'(rd_round) < ROUNDS) && (int'(rd_slot) < SLOTS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        kind_q[i] <= SK_EMPTY;
        id_q[i]   <= '0;
      end
    end else if (wr_en && wr_in_range) begin
      kind_q[wr_idx] <= wr_kind;
      id_q[wr_idx]   <= wr_id;
    end
  end

  always_comb begin
    if (rd_in_range) begin
      rd_kind = kind_q[rd_idx];
      rd_id   = id_q[rd_idx];
    end else begin
      rd_kind = SK_FOREIGN;
      rd_id   = '0;
    end
  end
endmodule

// File: rtl/tdma_timed_bufs.sv
module tdma_timed_bufs #(
  parameter int N_TIMED = 4,
  parameter int ID_W    = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ID_W-1:0]   rd_id,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] data_q [N_TIMED];
  logic [N_TIMED-1:0] valid_q;

  for (genvar g = 0; g < N_TIMED; g++) begin : g_buf
    logic hit;
    assign hit = wr_en && (int'(wr_id) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        data_q[g]  <= '0;
      end else if (hit) begin
        valid_q[g] <= 1'b1;
        data_q[g]  <= wr_data;
      end
    end
  end

  always_comb begin
    if (int'(rd_id) < N_TIMED) begin
      rd_valid = valid_q[rd_id];
      rd_data  = data_q[rd_id];
    end else begin
      rd_valid = 1'b0;
      rd_data  = '0;
    end
  end
endmodule

// File: rtl/tdma_async_fifo.sv
module tdma_async_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic              ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, wr_ptr_n, rd_ptr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ovf_q, ovf_n;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (cnt_q == '0);
    full     = (int'(cnt_q) == DEPTH);
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_n = do_push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_n = do_pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_n    = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    ovf_n    = ovf_q || (push && full);
    head     = mem[rd_ptr_q];
    ovf      = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
      ovf_q    <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end
endmodule

// File: rtl/tdma_tx_sched.sv
module tdma_tx_sched #(
  parameter int ROUNDS   = 4,
  parameter int SLOTS    = 8,
  parameter int N_TIMED  = 4,
  parameter int AQ_DEPTH = 4,
  parameter int DATA_W   = 16,
  localparam int RND_W   = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int SLT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int ID_W    = (N_TIMED > 1) ? $clog2(N_TIMED) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [RND_W-1:0]  tbl_round,
  input  logic [SLT_W-1:0]  tbl_slot,
  input  logic [1:0]        tbl_kind,
  input  logic [ID_W-1:0]   tbl_id,
  input  logic              tmsg_we,
  input  logic [ID_W-1:0]   tmsg_id,
  input  logic [DATA_W-1:0] tmsg_data,
  input  logic              amsg_we,
  input  logic [DATA_W-1:0] amsg_data,
  output logic              amsg_full,
  output logic              amsg_ovf,
  input  logic              slot_start,
  input  logic [RND_W-1:0]  cur_round,
  input  logic [SLT_W-1:0]  cur_slot,
  output logic              tx_req,
  output logic              tx_async,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done,
  input  logic              tx_ok
);
  import tdma_sched_pkg::*;

  slot_kind_e        look_kind;
  logic [ID_W-1:0]   look_id;
  logic              tb_valid;
  logic [DATA_W-1:0] tb_data;
  logic [DATA_W-1:0] fifo_head;
  logic              fifo_empty;
  logic              fifo_pop;

  logic              req_q, req_n;
  logic              async_q, async_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              inflight_q, inflight_n;

  tdma_sched_table #(
    .ROUNDS(ROUNDS), .SLOTS(SLOTS), .RND_W(RND_W), .SLT_W(SLT_W), .ID_W(ID_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_round(tbl_round), .wr_slot(tbl_slot),
    .wr_kind(slot_kind_e'(tbl_kind)), .wr_id(tbl_id),
    .rd_round(cur_round), .rd_slot(cur_slot),
    .rd_kind(look_kind), .rd_id(look_id)
  );

  tdma_timed_bufs #(
    .N_TIMED(N_TIMED), .ID_W(ID_W), .DATA_W(DATA_W)
  ) u_timed (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tmsg_we), .wr_id(tmsg_id), .wr_data(tmsg_data),
    .rd_id(look_id), .rd_valid(tb_valid), .rd_data(tb_data)
  );

  tdma_async_fifo #(
    .DEPTH(AQ_DEPTH), .DATA_W(DATA_W)
  ) u_aq (
    .clk(clk), .rst_n(rst_n),
    .push(amsg_we), .push_data(amsg_data), .pop(fifo_pop),
    .head(fifo_head), .empty(fifo_empty), .full(amsg_full), .ovf(amsg_ovf)
  );

  // next-state: slot decision and async in-flight tracking
  always_comb begin
    req_n      = 1'b0;
    async_n    = async_q;
    data_n     = data_q;
    inflight_n = inflight_q;
    if (tx_done) inflight_n = 1'b0;
    if (slot_start) begin
      unique case (look_kind)
        SK_OWN: begin
          if (tb_valid) begin
            req_n   = 1'b1;
            async_n = 1'b0;
            data_n  = tb_data;
          end
        end
        SK_EMPTY: begin
          if (!fifo_empty && !inflight_q) begin
            req_n      = 1'b1;
            async_n    = 1'b1;
            data_n     = fifo_head;
            inflight_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
    fifo_pop = tx_done && tx_ok && inflight_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      async_q    <= 1'b0;
      data_q     <= '0;
      inflight_q <= 1'b0;
    end else begin
      req_q      <= req_n;
      inflight_q <= inflight_n;
      if (req_n) begin
        async_q <= async_n;
        data_q  <= data_n;
      end
    end
  end

  assign tx_req   = req_q;
  assign tx_async = async_q;
  assign tx_data  = data_q;
endmodule

// File: rtl/tdma_tx_sched_chk.sv
module tdma_tx_sched_chk (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       slot_start,
  input logic                       tx_req,
  input logic                       tx_async,
  input logic                       amsg_we,
  input logic                       amsg_full,
  input logic                       amsg_ovf,
  input tdma_sched_pkg::slot_kind_e look_kind,
  input logic                       fifo_empty,
  input logic                       inflight_q
);
  import tdma_sched_pkg::*;

  assert_req_after_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(slot_start));

  assert_foreign_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && (look_kind == SK_FOREIGN || look_kind == SK_OTHER)) |=> !tx_req);

  assert_async_from_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_async) |-> $past(!fifo_empty));

  assert_one_async_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && inflight_q) |=> !(tx_req && tx_async));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    amsg_ovf |=> amsg_ovf);

  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amsg_ovf) |-> $past(amsg_we && amsg_full));
endmodule

bind tdma_tx_sched tdma_tx_sched_chk i_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
  .tx_req(tx_req), .tx_async(tx_async),
  .amsg_we(amsg_we), .amsg_full(amsg_full), .amsg_ovf(amsg_ovf),
  .look_kind(look_kind), .fifo_empty(fifo_empty), .inflight_q(inflight_q)
);

// File: tb/test_tdma_tx_sched.sv
`timescale 1ns/1ps
module test_tdma_tx_sched;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic tbl_we; logic [1:0] tbl_round; logic [2:0] tbl_slot; logic [1:0] tbl_kind; logic [1:0] tbl_id;
  logic tmsg_we; logic [1:0] tmsg_id; logic [DW-1:0] tmsg_data;
  logic amsg_we; logic [DW-1:0] amsg_data; logic amsg_full, amsg_ovf;
  logic slot_start; logic [1:0] cur_round; logic [2:0] cur_slot;
  logic tx_req, tx_async; logic [DW-1:0] tx_data;
  logic tx_done, tx_ok;

  int total = 0;
  int bad = 0;

  typedef struct { bit req; bit async; logic [DW-1:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  tdma_tx_sched i_tdma_tx_sched (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_round(tbl_round), .tbl_slot(tbl_slot), .tbl_kind(tbl_kind), .tbl_id(tbl_id),
    .tmsg_we(tmsg_we), .tmsg_id(tmsg_id), .tmsg_data(tmsg_data),
    .amsg_we(amsg_we), .amsg_data(amsg_data), .amsg_full(amsg_full), .amsg_ovf(amsg_ovf),
    .slot_start(slot_start), .cur_round(cur_round), .cur_slot(cur_slot),
    .tx_req(tx_req), .tx_async(tx_async), .tx_data(tx_data),
    .tx_done(tx_done), .tx_ok(tx_ok)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each slot outcome against the scoreboard
  initial begin
    bit hit;
    forever begin
      @(posedge clk);
      hit = (slot_start === 1'b1);
      @(negedge clk);
      if (hit) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check("R2 scoreboard underflow", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " req"}, {31'd0, tx_req}, {31'd0, e.req});
          if (e.req && tx_req === 1'b1) begin
            check({e.tag, " async"}, {31'd0, tx_async}, {31'd0, e.async});
            check({e.tag, " data"}, {16'd0, tx_data}, {16'd0, e.data});
          end
        end
      end else if (rst_n === 1'b1 && tx_req !== 1'b0) begin
        check("R2 request outside slot start", {31'd0, tx_req}, 0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_tbl(input int r, input int s, input int k, input int id);
    tbl_we = 1; tbl_round = 2'(r); tbl_slot = 3'(s); tbl_kind = 2'(k); tbl_id = 2'(id);
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic put_timed(input int id, input logic [DW-1:0] d);
    tmsg_we = 1; tmsg_id = 2'(id); tmsg_data = d;
    @(negedge clk); tmsg_we = 0;
  endtask

  task automatic put_async(input logic [DW-1:0] d);
    amsg_we = 1; amsg_data = d;
    @(negedge clk); amsg_we = 0;
  endtask

  // driver: pushes the expected outcome, then fires the slot
  task automatic slot(input int r, input int s, input bit req, input bit as,
                      input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.req = req; e.async = as; e.data = d; e.tag = tag;
    exp_q.push_back(e);
    cur_round = 2'(r); cur_slot = 3'(s); slot_start = 1;
    @(negedge clk); slot_start = 0;
    idle(2);
  endtask

  task automatic done(input bit ok);
    tx_done = 1; tx_ok = ok;
    @(negedge clk); tx_done = 0; tx_ok = 0;
    idle(1);
  endtask

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; tbl_we = 0; tbl_round = 0; tbl_slot = 0; tbl_kind = 0; tbl_id = 0;
    tmsg_we = 0; tmsg_id = 0; tmsg_data = 0; amsg_we = 0; amsg_data = 0;
    slot_start = 0; cur_round = 0; cur_slot = 0; tx_done = 0; tx_ok = 0;
    idle(3);
    check("R10 tx_req after reset", {31'd0, tx_req}, 0);
    check("R10 full after reset", {31'd0, amsg_full}, 0);
    check("R10 ovf after reset", {31'd0, amsg_ovf}, 0);
    rst_n = 1;
    idle(2);

    // R1 table: round0 s0 own id0, s1 foreign, s3 own id1, s4 kind 3; round1 s0 own id0
    put_tbl(0, 0, 1, 0);
    put_tbl(0, 1, 2, 0);
    put_tbl(0, 3, 1, 1);
    put_tbl(0, 4, 3, 0);
    put_tbl(1, 0, 1, 0);

    slot(0, 0, 0, 0, 0, "R3 unwritten buffer");
    slot(1, 6, 0, 0, 0, "R5 empty slot empty queue");

    put_timed(0, 16'hA001);
    put_timed(0, 16'hA002);
    slot(0, 0, 1, 0, 16'hA002, "R3 overwrite R1 own slot");
    done(1);
    slot(1, 0, 1, 0, 16'hA002, "R1 round1 own slot");
    done(1);

    put_async(16'h0100);
    put_async(16'h0101);
    put_async(16'h0102);
    put_async(16'h0103);
    check("R9 full at depth", {31'd0, amsg_full}, 1);
    check("R9 no ovf yet", {31'd0, amsg_ovf}, 0);
    put_async(16'h0104);
    check("R9 ovf set", {31'd0, amsg_ovf}, 1);

    slot(0, 1, 0, 0, 0, "R4 foreign kind2 with queue");
    slot(0, 4, 0, 0, 0, "R4 foreign kind3 with queue");

    slot(0, 2, 1, 1, 16'h0100, "R5 empty slot sends head");
    done(0);
    check("R7 still full after failure", {31'd0, amsg_full}, 1);
    slot(2, 5, 1, 1, 16'h0100, "R7 retry at next empty slot");
    done(1);
    check("R7 pop frees space", {31'd0, amsg_full}, 0);
    slot(0, 2, 1, 1, 16'h0101, "R6 order second");
    done(1);
    slot(3, 7, 1, 1, 16'h0102, "R6 order third");
    done(1);
    slot(0, 2, 1, 1, 16'h0103, "R6 order fourth");
    done(1);
    slot(0, 2, 0, 0, 0, "R9 rejected write never sent");

    slot(0, 3, 0, 0, 0, "R3 id1 unwritten");
    put_timed(1, 16'hB00B);
    slot(0, 3, 1, 0, 16'hB00B, "R3 id1 written");
    done(0);
    idle(3);
    slot(0, 2, 0, 0, 0, "R8 failed timed not resent in empty slot");
    slot(0, 3, 1, 0, 16'hB00B, "R8 sent again at own slot");
    done(1);

    check("R9 ovf sticky", {31'd0, amsg_ovf}, 1);
    check("R2 scoreboard drained", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule